// File: doc/BRIEF.md
# GPIO Output and Output-Enable Register Pair with Masked Half-Word Writes

This block holds the value each GPIO pin drives and the per-pin enable that tells the pad control whether the pin drives at all. Each of the two words has three write ports. A full-word port replaces every bit. Two half-word ports each change a selected subset of one half. A half-word write carries its own bit mask, so a single bus write can set or clear individual pins without a read-modify-write sequence. This keeps updates atomic even when several software agents share the pins.

Writes use a one-hot-per-port strobe vector and a shared data word. Reads go through a combinational mux that is selected by a port address. The two held words go straight to the pads as `gpio_out` and `gpio_oe`. Both words come out of reset at zero, so no pin is driven until software enables it.

Top module: `gpio_mw_out`

## Requirements
- R1: While `rst_n` is low, and after it is released, both the output word and the enable word are all zeros, and so are `gpio_out` and `gpio_oe`.
- R2: A full-word strobe (wr_stb bit 0 for output, bit 3 for enable) loads all of `wr_data` into its word on the next rising clock edge. Reading address 0 (output) or address 3 (enable) returns the whole word.
- R3: A lower-half strobe (bit 1 output, bit 4 enable) takes its mask from `wr_data[31:16]` and its new values from `wr_data[15:0]`. Only word bits [15:0] whose mask bit is 1 take the new value. Every other bit keeps its value.
- R4: An upper-half strobe (bit 2 output, bit 5 enable) uses the same mask and data fields, and applies them to word bits [31:16]. Word bits [15:0] are not touched.
- R5: Reading a half port returns that half of the word in [15:0] and zero in [31:16]. Addresses 1 and 2 are the lower and upper halves of the output word. Addresses 4 and 5 are the lower and upper halves of the enable word.
- R6: A half-word write whose mask field is all zeros leaves the word unchanged.
- R7: When a full-word strobe and a half-word strobe for the same word are high in the same cycle, the full-word write wins, and the word equals `wr_data` afterwards.
- R8: Lower and upper strobes for the same word in the same cycle both apply, each to its own half.
- R9: The output word and the enable word are independent. A write to one never changes the other. With no strobe high, both words hold their values.
- R10: `gpio_out` and `gpio_oe` always equal the held words. Read addresses 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 6 | Per-port write strobes: 0/1/2 output full/lower/upper, 3/4/5 enable full/lower/upper |
| wr_data | input | 32 | Write data; for half ports, mask in [31:16] and values in [15:0] |
| rd_addr | input | 3 | Read port select, same numbering as `wr_stb` bits |
| rd_data | output | 32 | Combinational read data of the selected port |
| gpio_out | output | 32 | Pin output values to the pads |
| gpio_oe | output | 32 | Pin output enables to the pad control |

## Verification
The assertions take for granted that the strobes and the data are stable and known around each rising edge, and that `rd_addr` stays within its three bits. They place no limit on how many strobes are high together, so the same-cycle merge rules are checked as well. The bench changes every input only on the falling edge and samples the pads one falling edge after each write. It drives combined strobes on purpose in the R7 and R8 vectors, and it never leaves a strobe high for longer than one cycle.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
   localparam int PORTS_PER_WORD = 3;
   localparam int NUM_WORDS      = 2;
   localparam int NUM_PORTS      = PORTS_PER_WORD * NUM_WORDS;
   localparam int ADDR_W         = $clog2(NUM_PORTS + 2);

   typedef enum logic [2:0] {
      PORT_OUT_FULL = 3'd0,
      PORT_OUT_LO   = 3'd1,
      PORT_OUT_HI   = 3'd2,
      PORT_OE_FULL  = 3'd3,
      PORT_OE_LO    = 3'd4,
      PORT_OE_HI    = 3'd5
   } port_e;
endpackage

// File: rtl/gpio_mw_field.sv
module gpio_mw_field #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_full,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] q
);
   localparam int HALF = WIDTH / 2;

   initial begin
      if (WIDTH < 2 || (WIDTH % 2) != 0)
         $error("gpio_mw_field: WIDTH must be even and at least 2");
   end

   logic [HALF-1:0]  mask, val, lo_new, hi_new;
   logic [WIDTH-1:0] nxt;

   assign mask   = wr_data[WIDTH-1:HALF];
   assign val    = wr_data[HALF-1:0];
   assign lo_new = (q[HALF-1:0]     & ~mask) | (val & mask);
   assign hi_new = (q[WIDTH-1:HALF] & ~mask) | (val & mask);

   always_comb begin
      nxt = q;
      if (wr_lo) nxt[HALF-1:0]     = lo_new;
      if (wr_hi) nxt[WIDTH-1:HALF] = hi_new;
      if (wr_full) nxt = wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   // R2 and R7: a full-word write lands whole, whatever half strobes accompany it
   a_r2_full_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_full |=> q == $past(wr_data));
   // R3: a lower write alone leaves the upper half alone
   a_r3_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi && !wr_full) |=> q[WIDTH-1:HALF] == $past(q[WIDTH-1:HALF]));
   // R4: an upper write alone leaves the lower half alone
   a_r4_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo && !wr_full) |=> q[HALF-1:0] == $past(q[HALF-1:0]));
   // R6: an empty mask changes nothing
   a_r6_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_full && (wr_lo || wr_hi) && wr_data[WIDTH-1:HALF] == '0) |=> $stable(q));
   // R9: no strobe, no change
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_full && !wr_lo && !wr_hi) |=> $stable(q));
endmodule

// File: rtl/gpio_mw_rdmux.sv
module gpio_mw_rdmux
   import gpio_mw_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0]  out_q,
   input  logic [WIDTH-1:0]  oe_q,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WIDTH-1:0]  rd_data
);
   localparam int HALF = WIDTH / 2;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         PORT_OUT_FULL: rd_data = out_q;
         PORT_OUT_LO:   rd_data[HALF-1:0] = out_q[HALF-1:0];
         PORT_OUT_HI:   rd_data[HALF-1:0] = out_q[WIDTH-1:HALF];
         PORT_OE_FULL:  rd_data = oe_q;
         PORT_OE_LO:    rd_data[HALF-1:0] = oe_q[HALF-1:0];
         PORT_OE_HI:    rd_data[HALF-1:0] = oe_q[WIDTH-1:HALF];
         default:       rd_data = '0;
      endcase
   end
endmodule

// File: rtl/gpio_mw_out.sv
module gpio_mw_out
   import gpio_mw_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] wr_stb,
   input  logic [WIDTH-1:0]     wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [WIDTH-1:0]     rd_data,
   output logic [WIDTH-1:0]     gpio_out,
   output logic [WIDTH-1:0]     gpio_oe
);
   localparam int HALF = WIDTH / 2;

   logic [WIDTH-1:0] word_q [NUM_WORDS];

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      gpio_mw_field #(.WIDTH(WIDTH)) u_field (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_full (wr_stb[g*PORTS_PER_WORD]),
         .wr_lo   (wr_stb[g*PORTS_PER_WORD + 1]),
         .wr_hi   (wr_stb[g*PORTS_PER_WORD + 2]),
         .wr_data (wr_data),
         .q       (word_q[g])
      );
   end

   assign gpio_out = word_q[0];
   assign gpio_oe  = word_q[1];

   gpio_mw_rdmux #(.WIDTH(WIDTH)) u_rdmux (
      .out_q   (word_q[0]),
      .oe_q    (word_q[1]),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   // R5: the mask field of a half-port read is always zero
   a_r5_half_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == PORT_OUT_LO || rd_addr == PORT_OUT_HI ||
       rd_addr == PORT_OE_LO  || rd_addr == PORT_OE_HI) |-> rd_data[WIDTH-1:HALF] == '0);
   // R9: output-word strobes alone never move the enable pins
   a_r9_oe_independent: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb[5:3] == 3'b000) |=> $stable(gpio_oe));
   // R1: the cycle after reset releases, both words are still zero
   a_r1_reset_zero: assert property (@(posedge clk)
      !rst_n |=> (gpio_out == '0 && gpio_oe == '0));
endmodule

// File: tb/tb_gpio_mw_out.sv
`timescale 1ns/1ps
module tb_gpio_mw_out;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  wr_stb = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data, gpio_out, gpio_oe;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   gpio_mw_out dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
   );

   always #4 clk = ~clk;

   // {strobes, data, expected out, expected oe}
   localparam int NV = 10;
   localparam logic [101:0] VEC [NV] = '{
      {6'b000001, 32'hA5A5_F00F, 32'hA5A5_F00F, 32'h0000_0000}, // R2 out full
      {6'b000010, 32'h00FF_1234, 32'hA5A5_F034, 32'h0000_0000}, // R3 out lower
      {6'b000100, 32'hF000_0000, 32'h05A5_F034, 32'h0000_0000}, // R4 out upper
      {6'b001000, 32'hFFFF_0000, 32'h05A5_F034, 32'hFFFF_0000}, // R9 oe full, out untouched
      {6'b010000, 32'h0003_FFFF, 32'h05A5_F034, 32'hFFFF_0003}, // R3 oe lower
      {6'b100000, 32'h0000_1234, 32'h05A5_F034, 32'hFFFF_0003}, // R6 empty mask
      {6'b000110, 32'hFFFF_0000, 32'h0000_0000, 32'hFFFF_0003}, // R8 lower+upper
      {6'b000011, 32'h1234_5678, 32'h1234_5678, 32'hFFFF_0003}, // R7 full beats lower
      {6'b110000, 32'h8001_8001, 32'h1234_5678, 32'hFFFF_8003}, // R8 oe both halves
      {6'b000000, 32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_8003}  // R9 idle hold
   };
   localparam int VREQ [NV] = '{2, 3, 4, 9, 3, 6, 8, 7, 8, 9};

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      rd_addr = a;
      #1;
      check(tag, rd_data, exp);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 out in reset", gpio_out, 32'h0);
      check("R1 oe in reset", gpio_oe, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out after release", gpio_out, 32'h0);

      for (int i = 0; i < NV; i++) begin
         wr_stb  = VEC[i][101:96];
         wr_data = VEC[i][95:64];
         @(negedge clk);
         wr_stb = '0;
         check($sformatf("R%0d vec%0d out", VREQ[i], i), gpio_out, VEC[i][63:32]);
         check($sformatf("R%0d vec%0d oe", VREQ[i], i), gpio_oe, VEC[i][31:0]);
      end

      rd(3'd0, 32'h1234_5678, "R2 read out full");
      rd(3'd3, 32'hFFFF_8003, "R2 read oe full");
      rd(3'd1, 32'h0000_5678, "R5 read out lower");
      rd(3'd2, 32'h0000_1234, "R5 read out upper");
      rd(3'd4, 32'h0000_8003, "R5 read oe lower");
      rd(3'd5, 32'h0000_FFFF, "R5 read oe upper");
      rd(3'd6, 32'h0, "R10 read addr 6");
      rd(3'd7, 32'h0, "R10 read addr 7");

      // R6: empty mask on lower out port, then read back the half
      @(negedge clk);
      wr_stb = 6'b000010; wr_data = 32'h0000_FFFF;
      @(negedge clk);
      wr_stb = '0;
      rd(3'd1, 32'h0000_5678, "R6 empty lower mask");

      // R7: full beats upper on the enable word
      wr_stb = 6'b101000; wr_data = 32'hFFFF_0000;
      @(negedge clk);
      wr_stb = '0;
      check("R7 oe full beats upper", gpio_oe, 32'hFFFF_0000);
      check("R10 out pins hold word", gpio_out, 32'h1234_5678);

      // R1: reset mid-run clears both words
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 out after mid reset", gpio_out, 32'h0);
      check("R1 oe after mid reset", gpio_oe, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule